// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog counter clocked by the system clock. After every restart it counts clock cycles. When the count reaches a timeout chosen by a two-bit mode field, it sets a sticky interrupt flag. The flag reaches the interrupt request output only while the interrupt enable is set.

If software does not restart the counter, the block continues counting for a further fixed delay. At the end of that delay it issues a one-clock reset request and sets a sticky reset flag, but only when the reset enable is set. The reset flag lets software find out why the chip restarted. It is cleared only by a software clear or by the power-on reset of this block.

The timeout unit is 2^BASE_LOG2 clocks, which is 65536 by default. The second-stage delay RST_DELAY defaults to 256 clocks. A new mode value is taken only on a restart, so a period already running keeps its length. After the reset point the counter holds until the next restart and fires nothing more.

Top module: `wdt_two_stage`

## Requirements
- R1: After a restart, the interrupt flag rises exactly T clocks later, where T = U * 2^BASE_LOG2. U is 1, 4, 16 or 32 for mode codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R2: With the reset enable at 1, the reset request goes high for exactly one clock T + RST_DELAY clocks after the restart. The reset flag becomes 1 on the same edge.
- R3: With the reset enable at 0 at the reset point, no reset request is produced and the reset flag stays 0.
- R4: A restart strobe clears the count. All later events are timed from the most recent restart, and an event due on the same edge as a restart does not occur.
- R5: The interrupt request equals the interrupt flag ANDed with the interrupt enable, delayed by one registered clock. It stays 0 while the enable is 0.
- R6: Both flags stay set until their clear strobe is applied. A set and a clear on the same edge leave the flag set.
- R7: A change of the mode input takes effect only at the next restart. It does not shorten or lengthen the running period.
- R8: During and directly after the power-on reset, all four outputs are 0 and the counter runs a mode 2'b00 period.
- R9: After the reset point the counter holds. No further interrupt event or reset request occurs until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| restart_i | input | 1 | Single-cycle restart strobe |
| rst_en_i | input | 1 | Enables the reset stage |
| mode_i | input | 2 | Timeout select, sampled on restart |
| int_en_i | input | 1 | Routes the interrupt flag to irq_o |
| clr_int_i | input | 1 | Clears the interrupt flag (software writes 0) |
| clr_rst_i | input | 1 | Clears the reset flag (software writes 0) |
| int_flag_o | output | 1 | Sticky interrupt flag |
| rst_flag_o | output | 1 | Sticky reset-cause flag |
| irq_o | output | 1 | Registered interrupt request |
| rst_req_o | output | 1 | One-clock registered reset request |

## Verification
A restart strobe sampled on edge E0 clears the count. The interrupt flag is due on edge E0+T, irq_o on E0+T+1, and the reset request and reset flag on E0+T+RST_DELAY. The reset request falls again on the following edge.

The bench drives all inputs on falling edges and counts falling edges from E0. It samples one cycle before each due edge to confirm the output is still low, then samples right after the edge to confirm it has changed. The bench shrinks BASE_LOG2 and RST_DELAY so that every mode fits in the run. A bench-side pulse counter catches reset requests outside their window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WDT_X1  = 2'b00,
    WDT_X4  = 2'b01,
    WDT_X16 = 2'b10,
    WDT_X32 = 2'b11
  } wdt_mode_e;

  // timeout length in base units for a mode code
  function automatic int unsigned wdt_units(wdt_mode_e m);
    case (m)
      WDT_X1:  return 1;
      WDT_X4:  return 4;
      WDT_X16: return 16;
      default: return 32;
    endcase
  endfunction

  // interrupt threshold in clocks
  function automatic int unsigned wdt_thr_clocks(wdt_mode_e m, int unsigned base_log2);
    return wdt_units(m) << base_log2;
  endfunction
endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 16,
  parameter int CNT_W     = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] thr_o
);
  wdt_mode_e mode_q;

  // mode is captured only on restart, so a running period keeps its length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= WDT_X1;
    else if (restart_i) mode_q <= wdt_mode_e'(mode_i);
  end

  assign thr_o = CNT_W'(wdt_thr_clocks(mode_q, BASE_LOG2));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W     = 22,
  parameter int RST_DELAY = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             int_hit_o,
  output logic             rst_hit_o
);
  logic [CNT_W-1:0] term;
  logic             at_term;

  assign term    = thr_i + CNT_W'(RST_DELAY);
  assign at_term = (cnt_o == term);

  // count edges since restart; hold at the reset point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (!at_term)  cnt_o <= cnt_o + 1'b1;
  end

  // events fire on the edge where the count reaches the point; restart suppresses them
  assign int_hit_o = !restart_i && (cnt_o == thr_i - 1'b1);
  assign rst_hit_o = !restart_i && (cnt_o == term - 1'b1);
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_hit_i,
  input  logic rst_hit_i,
  input  logic rst_en_i,
  input  logic int_en_i,
  input  logic clr_int_i,
  input  logic clr_rst_i,
  output logic int_flag_o,
  output logic rst_flag_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic rst_fire;

  assign rst_fire = rst_hit_i && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_flag_o <= 1'b0;
      rst_flag_o <= 1'b0;
      irq_o      <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      // set has priority over clear
      if (int_hit_i)      int_flag_o <= 1'b1;
      else if (clr_int_i) int_flag_o <= 1'b0;
      if (rst_fire)       rst_flag_o <= 1'b1;
      else if (clr_rst_i) rst_flag_o <= 1'b0;
      irq_o     <= int_flag_o && int_en_i;
      rst_req_o <= rst_fire;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int BASE_LOG2 = 16,
  parameter int RST_DELAY = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       rst_en_i,
  input  logic [1:0] mode_i,
  input  logic       int_en_i,
  input  logic       clr_int_i,
  input  logic       clr_rst_i,
  output logic       int_flag_o,
  output logic       rst_flag_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  localparam int MaxTerm = (32 << BASE_LOG2) + RST_DELAY;
  localparam int CntW    = $clog2(MaxTerm + 1);

  logic [CntW-1:0] thr;
  logic [CntW-1:0] cnt;
  logic            int_hit;
  logic            rst_hit;

  wdt_period_sel #(.BASE_LOG2(BASE_LOG2), .CNT_W(CntW)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .mode_i   (mode_i),
    .thr_o    (thr)
  );

  wdt_counter #(.CNT_W(CntW), .RST_DELAY(RST_DELAY)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .thr_i    (thr),
    .cnt_o    (cnt),
    .int_hit_o(int_hit),
    .rst_hit_o(rst_hit)
  );

  wdt_flags u_flg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_hit_i (int_hit),
    .rst_hit_i (rst_hit),
    .rst_en_i  (rst_en_i),
    .int_en_i  (int_en_i),
    .clr_int_i (clr_int_i),
    .clr_rst_i (clr_rst_i),
    .int_flag_o(int_flag_o),
    .rst_flag_o(rst_flag_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             rst_en_i,
  input logic             int_en_i,
  input logic             clr_int_i,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_hit,
  input logic             int_flag_o,
  input logic             rst_flag_o,
  input logic             irq_o,
  input logic             rst_req_o
);
  p_rst_one_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_rst_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_flag_o);
  p_rst_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_hit && !rst_en_i) |=> !rst_req_o);
  p_restart_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt == '0));
  p_irq_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_flag_o && int_en_i) |=> irq_o);
  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |=> !irq_o);
  p_int_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_flag_o && !clr_int_i) |=> int_flag_o);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CntW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .rst_en_i  (rst_en_i),
  .int_en_i  (int_en_i),
  .clr_int_i (clr_int_i),
  .cnt       (cnt),
  .rst_hit   (rst_hit),
  .int_flag_o(int_flag_o),
  .rst_flag_o(rst_flag_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o)
);

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
  localparam int BASE = 4;
  localparam int DLY  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0, rst_en = 1'b0, int_en = 1'b0, clr_int = 1'b0, clr_rst = 1'b0;
  logic [1:0] mode = 2'b00;
  logic int_flag, rst_flag, irq, rst_req;
  int n_chk = 0, n_bad = 0, pulses = 0;

  always #5 clk = ~clk;

  wdt_two_stage #(.BASE_LOG2(BASE), .RST_DELAY(DLY)) i_wdt_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .rst_en_i(rst_en),
    .mode_i(mode), .int_en_i(int_en), .clr_int_i(clr_int), .clr_rst_i(clr_rst),
    .int_flag_o(int_flag), .rst_flag_o(rst_flag), .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) if (rst_req) pulses++;

  function automatic int tmo(input logic [1:0] m);
    int u;
    u = (m == 2'b00) ? 1 : (m == 2'b01) ? 4 : (m == 2'b10) ? 16 : 32;
    return u * (1 << BASE);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns just after edge E0 where restart was sampled
  task automatic do_restart;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic clear_flags;
    @(negedge clk) begin clr_int = 1'b1; clr_rst = 1'b1; end
    @(negedge clk) begin clr_int = 1'b0; clr_rst = 1'b0; end
  endtask

  task automatic t_reset_state;
    check("R8 int_flag", int_flag, 1'b0);
    check("R8 rst_flag", rst_flag, 1'b0);
    check("R8 irq", irq, 1'b0);
    check("R8 rst_req", rst_req, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(tmo(2'b00) - 2);
    check("R8 mode00 before", int_flag, 1'b0);
    wait_n(3);
    check("R8 mode00 period", int_flag, 1'b1);
    clear_flags();
  endtask

  task automatic t_timeout(input logic [1:0] m);
    int p0;
    mode = m; rst_en = 1'b0;
    do_restart();
    p0 = pulses;
    wait_n(tmo(m) - 1);
    check("R1 flag early", int_flag, 1'b0);
    wait_n(1);
    check("R1 flag on time", int_flag, 1'b1);
    wait_n(DLY + 4);
    check("R3 no rst_flag", rst_flag, 1'b0);
    check("R3 no rst_req", (pulses != p0), 1'b0);
    clear_flags();
  endtask

  task automatic t_reset_path;
    int p0;
    mode = 2'b00; rst_en = 1'b1; int_en = 1'b1;
    do_restart();
    p0 = pulses;
    wait_n(tmo(2'b00));
    check("R5 irq lags", irq, 1'b0);
    wait_n(1);
    check("R5 irq", irq, 1'b1);
    wait_n(DLY - 2);
    check("R2 rst_req early", rst_req, 1'b0);
    wait_n(1);
    check("R2 rst_req", rst_req, 1'b1);
    check("R2 rst_flag", rst_flag, 1'b1);
    wait_n(1);
    check("R2 one clock", rst_req, 1'b0);
    wait_n(60);
    check("R9 hold no rerun", (pulses - p0 == 1), 1'b1);
    check("R6 rst_flag sticky", rst_flag, 1'b1);
    check("R6 int_flag sticky", int_flag, 1'b1);
    int_en = 1'b0;
    wait_n(2);
    check("R5 masked", irq, 1'b0);
    clear_flags();
    check("R6 int cleared", int_flag, 1'b0);
    check("R6 rst cleared", rst_flag, 1'b0);
    rst_en = 1'b0;
  endtask

  task automatic t_restart;
    mode = 2'b00;
    do_restart();
    wait_n(tmo(2'b00) - 3);
    do_restart();
    wait_n(tmo(2'b00) - 1);
    check("R4 no early flag", int_flag, 1'b0);
    wait_n(1);
    check("R4 flag from last restart", int_flag, 1'b1);
    clear_flags();
  endtask

  task automatic t_mode_change;
    mode = 2'b00;
    do_restart();
    wait_n(3);
    mode = 2'b11;
    wait_n(tmo(2'b00) - 4);
    check("R7 old period early", int_flag, 1'b0);
    wait_n(1);
    check("R7 old period kept", int_flag, 1'b1);
    clear_flags();
    do_restart();
    wait_n(tmo(2'b11) - 1);
    check("R7 new period early", int_flag, 1'b0);
    wait_n(1);
    check("R7 new period", int_flag, 1'b1);
    clear_flags();
  endtask

  task automatic t_set_wins;
    mode = 2'b00;
    do_restart();
    clr_int = 1'b1;
    wait_n(tmo(2'b00));
    check("R6 set beats clear", int_flag, 1'b1);
    wait_n(1);
    check("R6 clear next", int_flag, 1'b0);
    clr_int = 1'b0;
  endtask

  initial begin
    fork
      begin
        wait_n(3);
        t_reset_state();
        t_timeout(2'b00);
        t_timeout(2'b01);
        t_timeout(2'b10);
        t_timeout(2'b11);
        t_reset_path();
        t_restart();
        t_mode_change();
        t_set_wins();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule